// File: doc/BRIEF.md
# Streaming Read-Increment-Write Engine

The engine walks over `n` consecutive 64-bit elements of an external memory, beginning at element index 0, and replaces each element with its value plus one. Five independent valid/ready streams connect it to the memory: read address, read data, write address, write data and write acknowledgement. Read requests run ahead of the returning data. Each returned word is forwarded to the write side in the same cycle it is accepted. Reads, writes and acknowledgements all progress at the same time, so throughput is one element per cycle whenever the memory keeps up.

Software, or a neighbouring block, pulses `start` with the element count. The engine then raises `busy` until every element has been read back and every write has been acknowledged. After that it holds `done`. The memory acknowledges writes in groups. Each token says how many writes it covers, so the engine must keep accepting tokens or the write path would stall.

Top module: `rmw_incr_engine`

## Requirements
- R1: After reset `busy` and `done` are 0 and `rd_addr_valid`, `rd_data_ready`, `wr_addr_valid` and `wr_data_valid` are all 0.
- R2: The engine issues exactly `n` read requests per run. Their addresses are the element indices 0, 1, …, n-1 in ascending order, and a pending request keeps its address stable until accepted.
- R3: A read word is accepted (`rd_data_ready` high) only in a cycle where `wr_addr_ready` and `wr_data_ready` are both high. `wr_addr_valid` and `wr_data_valid` are asserted only in the cycle a read word is accepted.
- R4: The k-th write of a run goes to element index k. Its data equals the k-th read word plus one, modulo 2^64, so an all-ones word becomes zero.
- R5: An acknowledgement token with value v credits v+1 completed writes. `wr_resp_ready` is high in every cycle.
- R6: `busy` drops and `done` rises only once all `n` read words have been accepted and at least `n` writes have been credited. `done` then stays high until the next accepted `start`, which clears it.
- R7: A `start` pulse while `busy` is high is ignored: the running count, addresses and completion are unchanged.
- R8: Reads run ahead of their data. With read-address ready held high, two or more requests are issued before the first read word returns.
- R9: A run with `n` = 0 issues no read or write and reaches `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, taken only while idle |
| count | input | CNT_W | Number of elements for the run |
| rd_addr_valid | output | 1 | Read request pending |
| rd_addr_ready | input | 1 | Memory accepts read request |
| rd_addr | output | ADDR_W | Element index to read |
| rd_data_valid | input | 1 | Read word available |
| rd_data_ready | output | 1 | Engine takes read word |
| rd_data | input | DATA_W | Read word |
| wr_addr_valid | output | 1 | Write address pending |
| wr_addr_ready | input | 1 | Memory has room for a write address |
| wr_addr | output | ADDR_W | Element index to write |
| wr_data_valid | output | 1 | Write data pending |
| wr_data_ready | input | 1 | Memory has room for write data |
| wr_data | output | DATA_W | Incremented word |
| wr_resp_valid | input | 1 | Acknowledgement token available |
| wr_resp_ready | output | 1 | Token accepted |
| wr_resp | input | RESP_W | Token value: number of writes covered minus one |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |

## Verification
The bench sweeps counts from 0 to the full 16-element memory. It combines memory latencies, random back-pressure on each stream and acknowledgement group sizes of one to four. An engine that counted one write per token would never finish and would hit the run timeout. A data path without wrap-around would fail on the all-ones word. An engine that accepted read data while either write stream was full would drop a write, and that shows up as a missing incremented word in the memory image. The bench also covers a restart attempt mid-run, which must not shorten or restart the sweep, and a zero-length run, which must finish with no traffic.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef struct packed {
        logic busy;
        logic done;
    } ctrl_t;

endpackage

// File: rtl/rmw_rd_issue.sv
module rmw_rd_issue #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] n,
    input  logic             req_ready,
    output logic             req_valid,
    output logic [CNT_W-1:0] req_idx
);

    typedef struct packed {
        logic [CNT_W-1:0] idx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        req_valid = en && (st_q.idx < n);
        if (clr) begin
            st_d.idx = '0;
        end else if (req_valid && req_ready) begin
            st_d.idx = st_q.idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_idx = st_q.idx;

endmodule

// File: rtl/rmw_pair_inc.sv
module rmw_pair_inc #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [CNT_W-1:0]  n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              wa_ready,
    input  logic              wd_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic [CNT_W-1:0]  out_idx,
    output logic [DATA_W-1:0] out_data,
    output logic [CNT_W-1:0]  rsp_cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] rsp;
        logic [CNT_W-1:0] wrq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        in_ready  = en && (st_q.rsp < n) && wa_ready && wd_ready;
        out_valid = in_ready && in_valid;
        out_data  = in_data + DATA_W'(1);
        if (clr) begin
            st_d.rsp = '0;
            st_d.wrq = '0;
        end else if (out_valid) begin
            st_d.rsp = st_q.rsp + CNT_W'(1);
            st_d.wrq = st_q.wrq + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_idx = st_q.wrq;
    assign rsp_cnt = st_q.rsp;

endmodule

// File: rtl/rmw_ack_accum.sv
module rmw_ack_accum #(
    parameter int CNT_W  = 16,
    parameter int RESP_W = 8,
    localparam int ACC_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              tok_valid,
    input  logic [RESP_W-1:0] tok,
    output logic              tok_ready,
    output logic [ACC_W-1:0]  total
);

    localparam logic [ACC_W:0] SAT = {1'b0, {ACC_W{1'b1}}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;
    logic [ACC_W:0] sum;

    always_comb begin
        st_d      = st_q;
        tok_ready = 1'b1;
        sum       = {1'b0, st_q.acc} + (ACC_W+1)'(tok) + (ACC_W+1)'(1);
        if (clr) begin
            st_d.acc = '0;
        end else if (en && tok_valid) begin
            st_d.acc = (sum > SAT) ? SAT[ACC_W-1:0] : sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign total = st_q.acc;

endmodule

// File: rtl/rmw_incr_engine.sv
module rmw_incr_engine #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int RESP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  count,
    output logic              rd_addr_valid,
    input  logic              rd_addr_ready,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_data_valid,
    output logic              rd_data_ready,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_addr_valid,
    input  logic              wr_addr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_data_valid,
    input  logic              wr_data_ready,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_resp_valid,
    output logic              wr_resp_ready,
    input  logic [RESP_W-1:0] wr_resp,
    output logic              busy,
    output logic              done
);

    import rmw_pkg::*;

    localparam int ACC_W = CNT_W + 1;

    ctrl_t            ctrl_d, ctrl_q;
    logic [CNT_W-1:0] n_d, n_q;
    logic             launch, finish, run_en;
    logic [CNT_W-1:0] rd_idx, wr_idx, rsp_cnt;
    logic [ACC_W-1:0] ack_cnt;
    logic             pair_valid;

    assign launch = start && !ctrl_q.busy;
    assign run_en = ctrl_q.busy;

    rmw_rd_issue #(.CNT_W(CNT_W)) u_rd_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (launch),
        .en        (run_en),
        .n         (n_q),
        .req_ready (rd_addr_ready),
        .req_valid (rd_addr_valid),
        .req_idx   (rd_idx)
    );

    rmw_pair_inc #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (launch),
        .en        (run_en),
        .n         (n_q),
        .in_valid  (rd_data_valid),
        .in_data   (rd_data),
        .wa_ready  (wr_addr_ready),
        .wd_ready  (wr_data_ready),
        .in_ready  (rd_data_ready),
        .out_valid (pair_valid),
        .out_idx   (wr_idx),
        .out_data  (wr_data),
        .rsp_cnt   (rsp_cnt)
    );

    rmw_ack_accum #(.CNT_W(CNT_W), .RESP_W(RESP_W)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (launch),
        .en        (run_en),
        .tok_valid (wr_resp_valid),
        .tok       (wr_resp),
        .tok_ready (wr_resp_ready),
        .total     (ack_cnt)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        n_d    = n_q;
        finish = ctrl_q.busy && (rsp_cnt >= n_q) && (ack_cnt >= ACC_W'(n_q));
        if (launch) begin
            ctrl_d.busy = 1'b1;
            ctrl_d.done = 1'b0;
            n_d         = count;
        end else if (finish) begin
            ctrl_d.busy = 1'b0;
            ctrl_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            n_q    <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            n_q    <= n_d;
        end
    end

    assign rd_addr       = ADDR_W'(rd_idx);
    assign wr_addr       = ADDR_W'(wr_idx);
    assign wr_addr_valid = pair_valid;
    assign wr_data_valid = pair_valid;
    assign busy          = ctrl_q.busy;
    assign done          = ctrl_q.done;

endmodule

// File: rtl/rmw_incr_engine_chk.sv
module rmw_incr_engine_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_addr_valid,
    input logic              rd_addr_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_data_valid,
    input logic              rd_data_ready,
    input logic              wr_addr_valid,
    input logic              wr_addr_ready,
    input logic              wr_data_valid,
    input logic              wr_data_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              busy,
    input logic              done
);

    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_valid && !rd_addr_ready |=> rd_addr_valid && $stable(rd_addr));

    assert_rd_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_valid && rd_addr_ready |=> !rd_addr_valid || rd_addr == $past(rd_addr) + ADDR_W'(1));

    assert_wr_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr_valid |-> wr_addr_ready && wr_data_ready && rd_data_valid && rd_data_ready);

    assert_wr_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr_valid == wr_data_valid);

    assert_wr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr_valid |=> !wr_addr_valid || wr_addr == $past(wr_addr) + ADDR_W'(1));

    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !rd_addr_valid && !wr_addr_valid);

    assert_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind rmw_incr_engine rmw_incr_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .rd_addr_valid (rd_addr_valid),
    .rd_addr_ready (rd_addr_ready),
    .rd_addr       (rd_addr),
    .rd_data_valid (rd_data_valid),
    .rd_data_ready (rd_data_ready),
    .wr_addr_valid (wr_addr_valid),
    .wr_addr_ready (wr_addr_ready),
    .wr_data_valid (wr_data_valid),
    .wr_data_ready (wr_data_ready),
    .wr_addr       (wr_addr),
    .busy          (busy),
    .done          (done)
);

// File: tb/rmw_incr_engine_tb.sv
module rmw_incr_engine_tb;

    localparam int DATA_W = 64;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int RESP_W = 8;
    localparam int MEM_N  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  count = '0;
    logic              rd_addr_valid, rd_data_ready, wr_addr_valid, wr_data_valid, wr_resp_ready;
    logic              rd_addr_ready = 1'b0, rd_data_valid = 1'b0;
    logic              wr_addr_ready = 1'b0, wr_data_ready = 1'b0, wr_resp_valid = 1'b0;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data = '0, wr_data;
    logic [RESP_W-1:0] wr_resp = '0;
    logic              busy, done;

    always #5 clk = ~clk;

    rmw_incr_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESP_W(RESP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .count(count),
        .rd_addr_valid(rd_addr_valid), .rd_addr_ready(rd_addr_ready), .rd_addr(rd_addr),
        .rd_data_valid(rd_data_valid), .rd_data_ready(rd_data_ready), .rd_data(rd_data),
        .wr_addr_valid(wr_addr_valid), .wr_addr_ready(wr_addr_ready), .wr_addr(wr_addr),
        .wr_data_valid(wr_data_valid), .wr_data_ready(wr_data_ready), .wr_data(wr_data),
        .wr_resp_valid(wr_resp_valid), .wr_resp_ready(wr_resp_ready), .wr_resp(wr_resp),
        .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] init_mem [MEM_N];
    logic [DATA_W-1:0] out_mem  [MEM_N];
    localparam logic [DATA_W-1:0] UNTOUCHED = 64'h0BAD_0BAD_0BAD_0BAD;

    int cur_n = 0, lat = 1, mode = 0, grp = 1;
    int cyc = 0;
    int q_addr [64];
    int q_time [64];
    int q_h = 0, q_t = 0;
    int exp_rd = 0, exp_wr = 0, pending = 0, acked = 0, early_reads = 0, wr_seen = 0;
    bit seen_rsp = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit f_ra = 0, f_rd = 0, f_w = 0, f_b = 0;
    int cap_ra = 0, cap_wa = 0, cap_tok = 0;
    logic [DATA_W-1:0] cap_wd = '0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: drives at the falling edge, captures handshakes 1 ns later.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (f_ra) begin
                q_addr[q_t % 64] = cap_ra;
                q_time[q_t % 64] = cyc + lat;
                q_t++;
                if (!seen_rsp) early_reads++;
                check(cap_ra == exp_rd && cap_ra < cur_n, "R2 read index", 64'(cap_ra), 64'(exp_rd));
                exp_rd++;
            end
            if (f_rd) begin
                q_h++;
                seen_rsp = 1;
            end
            if (f_w) begin
                check(cap_wa == exp_wr, "R4 write index", 64'(cap_wa), 64'(exp_wr));
                if (cap_wa >= 0 && cap_wa < MEM_N) begin
                    check(cap_wd == init_mem[cap_wa] + 64'd1, "R4 write data", cap_wd, init_mem[cap_wa] + 64'd1);
                    out_mem[cap_wa] = cap_wd;
                end
                exp_wr++;
                pending++;
                wr_seen++;
            end
            if (f_b) begin
                pending -= cap_tok + 1;
                acked   += cap_tok + 1;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rd_addr_ready = (mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
            wr_addr_ready = (mode == 0) ? 1'b1 : (lfsr[1] | lfsr[6]);
            wr_data_ready = (mode == 0) ? 1'b1 : (lfsr[2] | lfsr[9]);
            if (q_h != q_t && q_time[q_h % 64] <= cyc) begin
                rd_data_valid = 1'b1;
                rd_data = init_mem[q_addr[q_h % 64] % MEM_N];
            end else begin
                rd_data_valid = 1'b0;
            end
            if (pending > 0 && (lfsr[5] || pending >= grp)) begin
                wr_resp_valid = 1'b1;
                wr_resp = RESP_W'(((pending < grp) ? pending : grp) - 1);
            end else begin
                wr_resp_valid = 1'b0;
            end
            #1;
            f_ra    = rd_addr_valid && rd_addr_ready;
            cap_ra  = int'(rd_addr);
            f_rd    = rd_data_valid && rd_data_ready;
            f_w     = wr_addr_valid;
            cap_wa  = int'(wr_addr);
            cap_wd  = wr_data;
            f_b     = wr_resp_valid && wr_resp_ready;
            cap_tok = int'(wr_resp);
            if (rst_n) begin
                if (rd_data_ready && !(wr_addr_ready && wr_data_ready))
                    check(0, "R3 read taken while write side full", 64'(rd_data_ready), 64'd0);
                if (wr_addr_valid != wr_data_valid || (wr_addr_valid && !(rd_data_valid && rd_data_ready)))
                    check(0, "R3 write valid without read transfer", 64'(wr_addr_valid), 64'd0);
                if (!wr_resp_ready)
                    check(0, "R5 ack ready low", 64'(wr_resp_ready), 64'd1);
            end
        end
    end

    task automatic run(input int n, input int l, input int m, input int g, input bit mid_start);
        int waited;
        @(negedge clk); #3;
        cur_n = n; lat = l; mode = m; grp = g;
        exp_rd = 0; exp_wr = 0; pending = 0; acked = 0; early_reads = 0; wr_seen = 0;
        seen_rsp = 0; q_h = 0; q_t = 0;
        for (int k = 0; k < MEM_N; k++) begin
            init_mem[k] = 64'hFFFF_FFFF_FFFF_FFFD + 64'(k) * 64'h0101_0000_0000_0001 + 64'(n * 64'h10000);
            if (k == 2) init_mem[k] = '1;
            out_mem[k] = UNTOUCHED;
        end
        start = 1'b1; count = CNT_W'(n);
        @(negedge clk); #3;
        start = 1'b0;
        check(busy && !done, "R6 start clears done and raises busy", {62'd0, busy, done}, 64'd2);
        if (mid_start) begin
            repeat (3) @(negedge clk);
            #3; start = 1'b1; count = CNT_W'(3);
            @(negedge clk); #3; start = 1'b0; count = CNT_W'(n);
        end
        waited = 0;
        while (!done && waited < 4000) begin
            @(negedge clk); #3;
            waited++;
        end
        check(done == 1'b1, "R6 run completes", 64'(done), 64'd1);
        check(!busy, "R6 busy dropped at completion", 64'(busy), 64'd0);
        check(exp_rd == n, mid_start ? "R7 read count after ignored start" : "R2 read count", 64'(exp_rd), 64'(n));
        check(wr_seen == n, mid_start ? "R7 write count after ignored start" : "R4 write count", 64'(wr_seen), 64'(n));
        check(acked == n && pending == 0, "R5 grouped acks credited", 64'(acked), 64'(n));
        for (int k = 0; k < MEM_N; k++) begin
            if (k < n)
                check(out_mem[k] == init_mem[k] + 64'd1, "R4 memory image", out_mem[k], init_mem[k] + 64'd1);
            else
                check(out_mem[k] == UNTOUCHED, "R2 element beyond n untouched", out_mem[k], UNTOUCHED);
        end
        if (m == 0 && l >= 3 && n >= 3)
            check(early_reads >= 2, "R8 reads outstanding before first data", 64'(early_reads), 64'd2);
        repeat (5) @(negedge clk);
        #3;
        check(done && !busy && !rd_addr_valid && !wr_addr_valid, "R6 done held while idle", 64'(done), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #3;
        check(!busy && !done && !rd_addr_valid && !rd_data_ready && !wr_addr_valid && !wr_data_valid,
              "R1 reset state", {58'd0, busy, done, rd_addr_valid, rd_data_ready, wr_addr_valid, wr_data_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk); #3;
        check(!busy && !done && !rd_addr_valid, "R1 idle after reset release", {61'd0, busy, done, rd_addr_valid}, 64'd0);

        run(0, 2, 0, 1, 0);   // R9 empty run
        check(wr_seen == 0 && exp_rd == 0, "R9 no traffic for zero count", 64'(wr_seen + exp_rd), 64'd0);
        for (int n = 1; n <= MEM_N; n++) begin
            for (int l = 1; l <= 6; l += 5) begin
                for (int m = 0; m < 2; m++) begin
                    run(n, l, m, 1 + (n % 4), 0);
                end
            end
        end
        run(10, 4, 1, 3, 1);  // R7 restart attempt mid-run
        run(16, 8, 0, 4, 1);  // R7 with full-rate streams
        run(0, 1, 1, 2, 0);   // R9 again after a long run
        check(exp_rd == 0, "R9 zero count after long run", 64'(exp_rd), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule